// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block models the logic core of a small programmable logic device. Twelve dedicated inputs and ten feedback signals drive 44 input lines, one line for the true value and one for the complement of each signal. A configuration store decides which lines are connected to each of 132 product terms. Each term is the AND of the lines connected to it. A term with no connections is TRUE. A term connected to both lines of the same signal is FALSE.

Of the 132 terms, 120 feed ten fixed OR gates. The groups have unequal, mirrored sizes from the lowest output to the highest: 8, 10, 12, 14, 16, 16, 14, 12, 10, 8. The other twelve terms go straight out of the block: ten output-enable terms, one preset term and one clear term. Logic further along the device consumes them.

Configuration is loaded through a one-bit serial port that shifts while the shift enable is high. A one-cycle erase strobe opens every connection. An erased array makes every output TRUE. A loader must therefore give each unused sum term a contradictory pair of connections.

Top module: `pal_sop_array`

## Requirements
- R1: After a synchronous active-low reset, every connection is open, so every output (sum, output-enable, preset, clear) reads 1 for any input values.
- R2: The cycle after an `cfg_erase` strobe, every connection is open. From then until new bits are shifted in, every output reads 1 for any input values.
- R3: While `cfg_shift` is high and `cfg_erase` is low, each clock moves one bit from `cfg_din` into the store. The k-th bit of a load of 5808 bits (k counted from 0) programs term k/44, line k%44. Line 2s is the true value of signal s and line 2s+1 is its complement. Signals 0 to 11 are `ded_in[0..11]` and signals 12 to 21 are `fb_in[0..9]`. A bit value of 1 means connected and 0 means open.
- R4: Terms 0 to 119 are the sum terms. They are assigned in consecutive groups to outputs 0 to 9 with sizes 8, 10, 12, 14, 16, 16, 14, 12, 10, 8. Term 120+i is the output-enable term for output i. Term 130 is the preset term and term 131 is the clear term.
- R5: A product term is the AND of its connected lines. A term with every connection open evaluates to 1.
- R6: A product term connected to both the true and the complement line of any one signal evaluates to 0.
- R7: `sum_out[o]` is the OR of the product terms in group o.
- R8: When `cfg_erase` and `cfg_shift` are both high in the same cycle, the erase wins. The store is cleared and the shifted bit is discarded.
- R9: While neither `cfg_shift` nor `cfg_erase` is high, the stored connections hold regardless of `cfg_din`.
- R10: All outputs are combinational in `ded_in` and `fb_in`. They follow a change of input within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Synchronous active-low reset; opens all connections |
| cfg_erase | input | 1 | One-cycle strobe that opens every connection |
| cfg_shift | input | 1 | Shift enable for the serial configuration port |
| cfg_din | input | 1 | Serial configuration data, one bit per shifting clock |
| ded_in | input | 12 | Dedicated input signals 0 to 11 |
| fb_in | input | 10 | Feedback input signals 12 to 21 |
| sum_out | output | 10 | OR of each output's product-term group |
| oe_term | output | 10 | Output-enable product term per output |
| preset_term | output | 1 | Global preset product term |
| clear_term | output | 1 | Global clear product term |

## Verification
An erase strobe and a serial shift can arrive in the same clock cycle. The bench provokes this by loading a full random pattern and then asserting erase and shift together with a data bit of 1. It then checks that every output reads 1 across random input vectors. That result is only possible if the store was cleared and not shifted by one position. Unprogrammed, erased and directed group-boundary patterns are all judged against a bench model of the array.

// File: rtl/pal_pkg.sv
// Shared sizes and group-layout functions for the sum-of-products array.
// Assumes a mirrored group layout: size grows by GRP_STEP from each end.
package pal_pkg;
    localparam int N_DED    = 12;
    localparam int N_FB     = 10;
    localparam int N_SIG    = N_DED + N_FB;
    localparam int N_LINE   = 2 * N_SIG;
    localparam int N_OUT    = 10;
    localparam int GRP_BASE = 8;
    localparam int GRP_STEP = 2;

    // Number of sum terms in the group that feeds output o.
    function automatic int grp_cnt(input int o);
        int k;
        k = (o < N_OUT / 2) ? o : (N_OUT - 1 - o);
        return GRP_BASE + GRP_STEP * k;
    endfunction

    // Index of the first sum term in the group that feeds output o.
    function automatic int grp_off(input int o);
        int acc;
        acc = 0;
        for (int i = 0; i < o; i++) acc += grp_cnt(i);
        return acc;
    endfunction

    localparam int N_SUM    = grp_off(N_OUT);
    localparam int OE_BASE  = N_SUM;
    localparam int PRE_IDX  = N_SUM + N_OUT;
    localparam int CLR_IDX  = PRE_IDX + 1;
    localparam int N_TERM   = CLR_IDX + 1;
    localparam int N_CFG    = N_TERM * N_LINE;
endpackage

// File: rtl/pal_cfg_chain.sv
// Serial configuration store: one long shift chain that shifts toward
// index 0, so the first bit loaded ends at index 0.
// Assumes erase and reset both clear the chain, and that erase takes
// priority over shift.
module pal_cfg_chain #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             erase,
    input  logic             shift,
    input  logic             din,
    output logic [WIDTH-1:0] cfg_q
);
    // Clear on reset or erase, otherwise shift one bit in when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || erase)
            cfg_q <= '0;
        else if (shift)
            cfg_q <= {din, cfg_q[WIDTH-1:1]};
    end

    // R3
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !erase) |=> (cfg_q[WIDTH-1] == $past(din)) &&
                              (cfg_q[WIDTH-2:0] == $past(cfg_q[WIDTH-1:1])));
    // R9
    hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift && !erase) |=> $stable(cfg_q));
endmodule

// File: rtl/pal_line_drv.sv
// Builds the true and complement input lines from the signal vector.
// Line 2s carries signal s and line 2s+1 carries its inverse.
module pal_line_drv #(
    parameter int N_SIG = 22
) (
    input  logic [N_SIG-1:0]   sig,
    output logic [2*N_SIG-1:0] lines
);
    for (genvar s = 0; s < N_SIG; s++) begin : g_line
        assign lines[2*s]   = sig[s];
        assign lines[2*s+1] = ~sig[s];
    end
endmodule

// File: rtl/pal_term.sv
// One product term: AND over the lines whose connection bit is 1.
// Assumes connection bit 1 = connected; an all-open term is TRUE.
module pal_term #(
    parameter int N_LINE = 44
) (
    input  logic [N_LINE-1:0] conn,
    input  logic [N_LINE-1:0] lines,
    output logic              hit
);
    localparam int N_PAIR = N_LINE / 2;

    // Evaluate the term and self-check its two special cases.
    always_comb begin
        logic contra;
        hit    = &(~conn | lines);
        contra = 1'b0;
        for (int s = 0; s < N_PAIR; s++)
            contra = contra | (conn[2*s] & conn[2*s+1]);
        // R6
        if (contra) begin
            contra_pair_chk: assert (!hit);
        end
        // R5
        if (conn == '0) begin
            open_true_chk: assert (hit);
        end
    end
endmodule

// File: rtl/pal_or_grp.sv
// Fixed OR gate over one group of product terms.
module pal_or_grp #(
    parameter int N_IN = 8
) (
    input  logic [N_IN-1:0] terms,
    output logic            y
);
    assign y = |terms;
endmodule

// File: rtl/pal_sop_array.sv
// Top of the programmable sum-of-products array. A serial store holds
// one connection bit per (term, line). The terms are combinational in
// the inputs. Sum terms feed unequal OR groups; the remaining terms
// leave the block directly.
// Assumes the store layout is term-major, line-minor.
module pal_sop_array
    import pal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_erase,
    input  logic             cfg_shift,
    input  logic             cfg_din,
    input  logic [N_DED-1:0] ded_in,
    input  logic [N_FB-1:0]  fb_in,
    output logic [N_OUT-1:0] sum_out,
    output logic [N_OUT-1:0] oe_term,
    output logic             preset_term,
    output logic             clear_term
);
    logic [N_CFG-1:0]  cfg_q;
    logic [N_LINE-1:0] lines;
    logic [N_TERM-1:0] term_hit;

    pal_cfg_chain #(.WIDTH(N_CFG)) i_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .erase (cfg_erase),
        .shift (cfg_shift),
        .din   (cfg_din),
        .cfg_q (cfg_q)
    );

    pal_line_drv #(.N_SIG(N_SIG)) i_lines (
        .sig   ({fb_in, ded_in}),
        .lines (lines)
    );

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        pal_term #(.N_LINE(N_LINE)) i_term (
            .conn  (cfg_q[t*N_LINE +: N_LINE]),
            .lines (lines),
            .hit   (term_hit[t])
        );
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_or
        localparam int OFF = grp_off(o);
        localparam int CNT = grp_cnt(o);
        pal_or_grp #(.N_IN(CNT)) i_or (
            .terms (term_hit[OFF +: CNT]),
            .y     (sum_out[o])
        );
    end

    assign oe_term     = term_hit[OE_BASE +: N_OUT];
    assign preset_term = term_hit[PRE_IDX];
    assign clear_term  = term_hit[CLR_IDX];

    // R2
    erase_all_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_erase |=> (&sum_out && &oe_term && preset_term && clear_term));
endmodule

// File: tb/test_pal_sop_array.sv
module test_pal_sop_array;
    localparam int NL = 44;
    localparam int NT = 132;
    localparam int NC = NT * NL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_erase = 1'b0;
    logic cfg_shift = 1'b0;
    logic cfg_din = 1'b0;
    logic [11:0] ded_in = '0;
    logic [9:0]  fb_in = '0;
    logic [9:0]  sum_out, oe_term;
    logic        preset_term, clear_term;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [NL-1:0] mdl [NT];
    int grp [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

    always #2 clk = ~clk;

    pal_sop_array i_pal_sop_array (
        .clk(clk), .rst_n(rst_n), .cfg_erase(cfg_erase), .cfg_shift(cfg_shift),
        .cfg_din(cfg_din), .ded_in(ded_in), .fb_in(fb_in), .sum_out(sum_out),
        .oe_term(oe_term), .preset_term(preset_term), .clear_term(clear_term)
    );

    // Reference model of the whole array from the requirements.
    function automatic logic [21:0] model(logic [11:0] d, logic [9:0] f);
        logic [21:0] s;
        logic [NT-1:0] th;
        logic [21:0] r;
        int off;
        s = {f, d};
        for (int t = 0; t < NT; t++) begin
            th[t] = 1'b1;
            for (int l = 0; l < NL; l++)
                if (mdl[t][l]) th[t] = th[t] & (l[0] ? ~s[l/2] : s[l/2]);
        end
        off = 0;
        r = '0;
        for (int o = 0; o < 10; o++) begin
            for (int k = 0; k < grp[o]; k++) r[o] = r[o] | th[off+k];
            off += grp[o];
        end
        r[19:10] = th[129:120];
        r[20] = th[130];
        r[21] = th[131];
        return r;
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic check(string tag, logic [11:0] d, logic [9:0] f);
        logic [21:0] exp_v, got;
        @(negedge clk);
        ded_in = d;
        fb_in = f;
        #1;
        exp_v = model(d, f);
        got = {clear_term, preset_term, oe_term, sum_out};
        n_chk++;
        if (got !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h (ded=%h fb=%h)", tag, got, exp_v, d, f);
        end
    endtask

    task automatic load_cfg();
        for (int k = 0; k < NC; k++) begin
            @(negedge clk);
            cfg_shift = 1'b1;
            cfg_din = mdl[k / NL][k % NL];
        end
        @(negedge clk);
        cfg_shift = 1'b0;
        cfg_din = 1'b0;
    endtask

    task automatic rand_cfg();
        for (int t = 0; t < NT; t++) begin
            int r;
            mdl[t] = '0;
            r = $urandom % 10;
            if (r == 0) continue;
            for (int j = 0; j < 2 + ($urandom % 3); j++) begin
                int s;
                s = $urandom % 22;
                mdl[t][2*s + ($urandom % 2)] = 1'b1;
            end
            if (r == 1) begin
                int s;
                s = $urandom % 22;
                mdl[t][2*s] = 1'b1;
                mdl[t][2*s+1] = 1'b1;
            end
        end
    endtask

    task automatic rand_vecs(string tag, int n);
        for (int i = 0; i < n; i++) check(tag, 12'($urandom), 10'($urandom));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int t = 0; t < NT; t++) mdl[t] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset leaves every connection open, so everything reads 1
        rand_vecs("R1 reset all open", 16);

        // R3 R4 R5 R6 R7 R10: random patterns against the model
        rand_cfg();
        load_cfg();
        rand_vecs("R3 R5 R6 R7 random pattern", 200);
        check("R10 same-cycle input", 12'hFFF, 10'h3FF);
        check("R10 same-cycle input", 12'h000, 10'h000);

        // R9: idle with toggling serial data keeps the pattern
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            cfg_din = 1'($urandom);
            check("R9 idle hold", 12'($urandom), 10'($urandom));
        end

        // R2: erase strobe, then an erased array reads constant 1
        @(negedge clk);
        cfg_erase = 1'b1;
        @(negedge clk);
        cfg_erase = 1'b0;
        for (int t = 0; t < NT; t++) mdl[t] = '0;
        rand_vecs("R2 erased reads 1", 24);

        // R4 R6: directed group-boundary pattern
        for (int t = 0; t < NT; t++) mdl[t] = 44'b11;
        begin
            int off;
            off = 0;
            for (int o = 0; o < 10; o++) begin
                mdl[off + grp[o] - 1] = '0;
                mdl[off + grp[o] - 1][2*o] = 1'b1;
                if (o % 2 == 0) begin
                    mdl[off] = '0;
                    mdl[off][2*(12+o)+1] = 1'b1;
                end
                off += grp[o];
            end
        end
        for (int i = 0; i < 10; i++) begin
            mdl[120+i] = '0;
            mdl[120+i][2*(12+i)] = 1'b1;
        end
        mdl[130] = '0;
        mdl[130][2*11+1] = 1'b1;
        mdl[131] = '0;
        load_cfg();
        check("R4 boundary zeros", 12'h000, 10'h000);
        check("R4 boundary ones", 12'hFFF, 10'h3FF);
        check("R4 boundary mix", 12'hA5A, 10'h155);
        rand_vecs("R4 R6 boundary random", 60);

        // R8: erase and shift together with din=1; erase must win
        rand_cfg();
        load_cfg();
        rand_vecs("R7 second pattern", 40);
        @(negedge clk);
        cfg_erase = 1'b1;
        cfg_shift = 1'b1;
        cfg_din = 1'b1;
        @(negedge clk);
        cfg_erase = 1'b0;
        cfg_shift = 1'b0;
        cfg_din = 1'b0;
        for (int t = 0; t < NT; t++) mdl[t] = '0;
        rand_vecs("R8 erase beats shift", 24);

        done = 1;
        finish_run();
    end
endmodule